// File: doc/BRIEF.md
# Packet Start and End Symbol Detector

This block sits behind the line decoder of a power-negotiation receiver. It takes one recovered, already BMC-decoded bit per strobe and hunts for the four-symbol K-code sequence that opens a packet. It reports which kind of start sequence it found (three packet-start variants and two reset variants) and then, for packet starts, turns each following 5-bit data code into a 4-bit nibble until the end-of-packet K-code arrives.

The detector does nothing until it is enabled and has seen the line idle. It then slides a 20-bit window over the incoming bits one bit at a time, so it needs no prior symbol alignment. A start sequence is accepted when enough of its four symbols match (three of four by default), and the aligned position of that match fixes the symbol boundaries for the data phase. A reset sequence is reported by itself, and the block then waits for idle again. An unknown code in the data phase is flagged and also sends the block back to waiting for idle.

Top module: `pd_ordset_detector`

## Requirements
- R1: After reset, and at every clock edge where `enable` is low, the block returns to waiting for idle and raises none of `sop_valid`, `data_valid`, `eop_seen` or `sym_err` in the following cycle.
- R2: While waiting for idle, strobed bits are ignored; the block starts hunting only after a clock edge with `enable` and `line_idle` both high.
- R3: Bits arrive least-significant bit first: a code written as `b4 b3 b2 b1 b0` is sent `b0` first. The window keeps the 20 most recent bits; its oldest symbol is the first of a sequence, and no start sequence is accepted until 20 bits have been strobed since hunting began.
- R4: Start sequences and their `sop_type` codes, with Sync-1 = 11000, Sync-2 = 10001, Sync-3 = 00110, Reset-1 = 00111, Reset-2 = 11001, first symbol first: 0 = S1,S1,S1,S2; 1 = S1,S1,S3,S3; 2 = S1,S3,S1,S3; 3 (hard reset) = R1,R1,R1,R2; 4 (cable reset) = R1,S1,R1,S3.
- R5: A sequence is accepted when at least `MIN_MATCH` (default 3) of its four symbols match in place; a window with only two matching symbols is not accepted.
- R6: When a window meets the threshold of more than one sequence, the lowest `sop_type` code wins.
- R7: After a start sequence of type 0, 1 or 2, each following group of 5 bits that is a data code raises `data_valid` with `data_nibble`; the codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R8: The end code 01101 in the data phase raises `eop_seen` and returns the block to waiting for idle.
- R9: Any other 5-bit code in the data phase raises `sym_err` and returns the block to waiting for idle.
- R10: Type 3 and type 4 sequences are reported with no data phase: the block returns to waiting for idle at once.
- R11: Each event output is a one-cycle pulse in the cycle after the clock edge that accepted the completing bit, and at most one event output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low forces waiting for idle |
| line_idle | input | 1 | Line is in the idle state |
| rx_bit | input | 1 | Recovered data bit |
| rx_bit_valid | input | 1 | Strobe marking `rx_bit` as a new bit |
| sop_valid | output | 1 | Pulse: start sequence recognised |
| sop_type | output | 3 | Kind of the last recognised start sequence |
| data_valid | output | 1 | Pulse: data nibble decoded |
| data_nibble | output | 4 | Last decoded nibble |
| eop_seen | output | 1 | Pulse: end-of-packet code seen |
| sym_err | output | 1 | Pulse: invalid code in the data phase |

## Verification
The assertions assume that a new bit is marked by a strobe that is high for exactly the clock cycle carrying it, and that `line_idle` is only raised between packets, never while a sequence is being hunted. The stimulus therefore presents each bit for one cycle with a gap after it, raises idle only after an end code, an error, a reset sequence or a disable, and precedes every sequence with an alternating preamble whose 5-bit groups are data codes rather than K-codes, so no misaligned window can reach the match threshold.

// File: rtl/pd_osd_pkg.sv
package pd_osd_pkg;

   localparam int SYM_W    = 5;
   localparam int NUM_SYMS = 4;
   localparam int WIN_W    = SYM_W * NUM_SYMS;
   localparam int NUM_SETS = 5;
   localparam int NIB_W    = 4;

   localparam logic [SYM_W-1:0] K_SYNC1 = 5'b11000;
   localparam logic [SYM_W-1:0] K_SYNC2 = 5'b10001;
   localparam logic [SYM_W-1:0] K_SYNC3 = 5'b00110;
   localparam logic [SYM_W-1:0] K_RST1  = 5'b00111;
   localparam logic [SYM_W-1:0] K_RST2  = 5'b11001;
   localparam logic [SYM_W-1:0] K_EOP   = 5'b01101;

   typedef enum logic [2:0] {
      OS_SOP    = 3'd0,
      OS_SOP_P  = 3'd1,
      OS_SOP_PP = 3'd2,
      OS_HARD   = 3'd3,
      OS_CABLE  = 3'd4
   } os_type_e;

   typedef enum logic [1:0] {
      ST_WAIT_IDLE = 2'd0,
      ST_HUNT      = 2'd1,
      ST_DATA      = 2'd2
   } osd_state_e;

   // Oldest symbol sits in the low bits of the pattern.
   function automatic logic [WIN_W-1:0] set_pattern(input int idx);
      case (idx)
         0:       return {K_SYNC2, K_SYNC1, K_SYNC1, K_SYNC1};
         1:       return {K_SYNC3, K_SYNC3, K_SYNC1, K_SYNC1};
         2:       return {K_SYNC3, K_SYNC1, K_SYNC3, K_SYNC1};
         3:       return {K_RST2,  K_RST1,  K_RST1,  K_RST1};
         default: return {K_SYNC3, K_RST1,  K_SYNC1, K_RST1};
      endcase
   endfunction

   // Returns {valid, nibble}.
   function automatic logic [NIB_W:0] decode_data(input logic [SYM_W-1:0] c);
      case (c)
         5'b11110: return {1'b1, 4'h0};
         5'b01001: return {1'b1, 4'h1};
         5'b10100: return {1'b1, 4'h2};
         5'b10101: return {1'b1, 4'h3};
         5'b01010: return {1'b1, 4'h4};
         5'b01011: return {1'b1, 4'h5};
         5'b01110: return {1'b1, 4'h6};
         5'b01111: return {1'b1, 4'h7};
         5'b10010: return {1'b1, 4'h8};
         5'b10011: return {1'b1, 4'h9};
         5'b10110: return {1'b1, 4'hA};
         5'b10111: return {1'b1, 4'hB};
         5'b11010: return {1'b1, 4'hC};
         5'b11011: return {1'b1, 4'hD};
         5'b11100: return {1'b1, 4'hE};
         5'b11101: return {1'b1, 4'hF};
         default:  return {1'b0, 4'h0};
      endcase
   endfunction

endpackage

// File: rtl/osd_window.sv
module osd_window #(
   parameter int WIDTH = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             clear_cnt,
   input  logic             bit_in,
   output logic [WIDTH-1:0] win_next,
   output logic             full_next
);
   localparam int CNT_W = $clog2(WIDTH + 1);

   logic [WIDTH-1:0] win_q;
   logic [CNT_W-1:0] fill_q;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("osd_window: WIDTH must be at least 2");
      end
   endgenerate

   // Newest bit enters at the top; the oldest bit leaves at bit 0.
   assign win_next  = {bit_in, win_q[WIDTH-1:1]};
   assign full_next = (fill_q >= CNT_W'(WIDTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (shift_en) begin
         win_q <= win_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (clear_cnt) begin
         fill_q <= '0;
      end else if (shift_en && (fill_q != CNT_W'(WIDTH))) begin
         fill_q <= fill_q + 1'b1;
      end
   end

endmodule

// File: rtl/osd_set_match.sv
module osd_set_match
   import pd_osd_pkg::*;
#(
   parameter int MIN_MATCH = 3
) (
   input  logic [WIN_W-1:0] win,
   output logic             any_hit,
   output os_type_e         hit_type
);
   logic [NUM_SETS-1:0] hit;

   generate
      if (MIN_MATCH < 1 || MIN_MATCH > NUM_SYMS) begin : g_bad_min
         $error("osd_set_match: MIN_MATCH out of range");
      end
      for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
         localparam logic [WIN_W-1:0] PAT = set_pattern(s);
         logic [NUM_SYMS-1:0] eq;
         for (genvar k = 0; k < NUM_SYMS; k++) begin : g_sym
            assign eq[k] = (win[k*SYM_W +: SYM_W] == PAT[k*SYM_W +: SYM_W]);
         end
         if (MIN_MATCH == NUM_SYMS) begin : g_exact
            assign hit[s] = &eq;
         end else begin : g_tolerant
            assign hit[s] = ($countones(eq) >= MIN_MATCH);
         end
      end
   endgenerate

   // Lowest index wins: scan downward so the last assignment is the lowest.
   always_comb begin
      hit_type = OS_SOP;
      for (int s = NUM_SETS - 1; s >= 0; s--) begin
         if (hit[s]) hit_type = os_type_e'(3'(s));
      end
   end

   assign any_hit = |hit;

endmodule

// File: rtl/osd_sym_decode.sv
module osd_sym_decode
   import pd_osd_pkg::*;
(
   input  logic [SYM_W-1:0] sym,
   output logic             is_data,
   output logic             is_eop,
   output logic [NIB_W-1:0] nibble
);
   logic [NIB_W:0] dec;

   assign dec     = decode_data(sym);
   assign is_data = dec[NIB_W];
   assign nibble  = dec[NIB_W-1:0];
   assign is_eop  = (sym == K_EOP);

endmodule

// File: rtl/pd_ordset_detector.sv
module pd_ordset_detector
   import pd_osd_pkg::*;
#(
   parameter int MIN_MATCH = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       line_idle,
   input  logic       rx_bit,
   input  logic       rx_bit_valid,
   output logic       sop_valid,
   output logic [2:0] sop_type,
   output logic       data_valid,
   output logic [3:0] data_nibble,
   output logic       eop_seen,
   output logic       sym_err
);
   localparam int DCNT_W = $clog2(SYM_W);

   osd_state_e        state_q;
   logic [WIN_W-1:0]  win_next;
   logic              full_next;
   logic              any_hit;
   os_type_e          hit_type;
   logic [DCNT_W-1:0] dcnt_q;
   logic              dec_data;
   logic              dec_eop;
   logic [NIB_W-1:0]  dec_nib;
   logic              sym_done;

   osd_window #(.WIDTH(WIN_W)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (rx_bit_valid),
      .clear_cnt (state_q != ST_HUNT),
      .bit_in    (rx_bit),
      .win_next  (win_next),
      .full_next (full_next)
   );

   osd_set_match #(.MIN_MATCH(MIN_MATCH)) u_match (
      .win      (win_next),
      .any_hit  (any_hit),
      .hit_type (hit_type)
   );

   osd_sym_decode u_decode (
      .sym     (win_next[WIN_W-1 -: SYM_W]),
      .is_data (dec_data),
      .is_eop  (dec_eop),
      .nibble  (dec_nib)
   );

   assign sym_done = (dcnt_q == DCNT_W'(SYM_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_WAIT_IDLE;
         dcnt_q      <= '0;
         sop_valid   <= 1'b0;
         sop_type    <= 3'd0;
         data_valid  <= 1'b0;
         data_nibble <= 4'h0;
         eop_seen    <= 1'b0;
         sym_err     <= 1'b0;
      end else begin
         sop_valid  <= 1'b0;
         data_valid <= 1'b0;
         eop_seen   <= 1'b0;
         sym_err    <= 1'b0;
         if (!enable) begin
            state_q <= ST_WAIT_IDLE;
         end else begin
            case (state_q)
               ST_WAIT_IDLE: begin
                  if (line_idle) state_q <= ST_HUNT;
               end
               ST_HUNT: begin
                  if (rx_bit_valid && full_next && any_hit) begin
                     sop_valid <= 1'b1;
                     sop_type  <= hit_type;
                     dcnt_q    <= '0;
                     state_q   <= (hit_type == OS_HARD || hit_type == OS_CABLE)
                                  ? ST_WAIT_IDLE : ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (rx_bit_valid) begin
                     if (sym_done) begin
                        dcnt_q <= '0;
                        if (dec_data) begin
                           data_valid  <= 1'b1;
                           data_nibble <= dec_nib;
                        end else if (dec_eop) begin
                           eop_seen <= 1'b1;
                           state_q  <= ST_WAIT_IDLE;
                        end else begin
                           sym_err <= 1'b1;
                           state_q <= ST_WAIT_IDLE;
                        end
                     end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                     end
                  end
               end
               default: state_q <= ST_WAIT_IDLE;
            endcase
         end
      end
   end

   // R11: events are exclusive and each one follows a strobed bit.
   a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sop_valid, data_valid, eop_seen, sym_err}));

   a_r11_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_valid || data_valid || eop_seen || sym_err) |-> $past(rx_bit_valid));

   // R1: a disabled edge yields no event in the next cycle.
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !(sop_valid || data_valid || eop_seen || sym_err));

   // R4: reported kind is always one of the five defined codes.
   a_r4_type_range: assert property (@(posedge clk) disable iff (!rst_n)
      sop_valid |-> (sop_type <= 3'd4));

   // R5: an exact packet-start window in the hunt is always taken as type 0.
   a_r5_exact_sop: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state_q == ST_HUNT && rx_bit_valid && full_next &&
       win_next == set_pattern(0)) |=> (sop_valid && sop_type == 3'd0));

   // R7: nibbles only come out while in the data phase.
   a_r7_data_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (state_q == ST_DATA));

   // R8 / R9: end code and bad code both leave the data phase.
   a_r8_eop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      eop_seen |-> (state_q == ST_WAIT_IDLE));

   a_r9_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
      sym_err |-> (state_q == ST_WAIT_IDLE));

   // R10: reset kinds never open a data phase.
   a_r10_reset_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_valid && sop_type >= 3'd3) |-> (state_q == ST_WAIT_IDLE));

endmodule

// File: tb/pd_ordset_detector_bench.sv
`timescale 1ns/1ps
module pd_ordset_detector_bench;

   localparam logic [4:0] S1 = 5'b11000;
   localparam logic [4:0] S2 = 5'b10001;
   localparam logic [4:0] S3 = 5'b00110;
   localparam logic [4:0] R1 = 5'b00111;
   localparam logic [4:0] RR2 = 5'b11001;
   localparam logic [4:0] EOPC = 5'b01101;
   localparam logic [4:0] BAD = 5'b00000;
   localparam logic [4:0] DCODE [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                         5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                         5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                         5'b11010, 5'b11011, 5'b11100, 5'b11101};

   localparam int EV_SOP = 0, EV_DATA = 1, EV_EOP = 2, EV_ERR = 3;

   typedef struct {
      int    kind;
      int    val;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       line_idle = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_bit_valid = 1'b0;
   logic       sop_valid;
   logic [2:0] sop_type;
   logic       data_valid;
   logic [3:0] data_nibble;
   logic       eop_seen;
   logic       sym_err;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t expq[$];

   always #5 clk = ~clk;

   pd_ordset_detector u_pd_ordset_detector (
      .clk(clk), .rst_n(rst_n), .enable(enable), .line_idle(line_idle),
      .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid),
      .sop_valid(sop_valid), .sop_type(sop_type),
      .data_valid(data_valid), .data_nibble(data_nibble),
      .eop_seen(eop_seen), .sym_err(sym_err));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input int val, input string req);
      exp_t e;
      e.kind = kind; e.val = val; e.req = req;
      expq.push_back(e);
   endtask

   // Monitor: compare each produced event against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n) begin
         int n;
         int kind;
         int val;
         n = int'(sop_valid) + int'(data_valid) + int'(eop_seen) + int'(sym_err);
         if (n > 1) check(1'b0, "R11", "simultaneous events", n, 1);
         if (n >= 1) begin
            kind = sop_valid ? EV_SOP : data_valid ? EV_DATA : eop_seen ? EV_EOP : EV_ERR;
            val  = sop_valid ? int'(sop_type) : data_valid ? int'(data_nibble) : 0;
            if (expq.size() == 0) begin
               check(1'b0, "R2", "unexpected event kind", kind, -1);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(kind == e.kind, e.req, "event kind", kind, e.kind);
               check(val == e.val, e.req, "event value", val, e.val);
            end
         end
      end
   end

   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      rx_bit_valid = 1'b1;
      @(negedge clk);
      rx_bit_valid = 1'b0;
   endtask

   // R3: low bit of each code goes out first.
   task automatic send_sym(input logic [4:0] c);
      for (int i = 0; i < 5; i++) send_bit(c[i]);
   endtask

   task automatic send_set(input logic [4:0] a, input logic [4:0] b,
                           input logic [4:0] c, input logic [4:0] d);
      send_sym(a); send_sym(b); send_sym(c); send_sym(d);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_packet();
      @(negedge clk);
      line_idle = 1'b1;
      wait_cycles(2);
      line_idle = 1'b0;
      for (int i = 0; i < 10; i++) send_bit(1'(i % 2));
   endtask

   task automatic drained(input string req);
      wait_cycles(3);
      check(expq.size() == 0, req, "pending expected events", expq.size(), 0);
   endtask

   initial begin
      wait_cycles(3);
      check(!sop_valid && !data_valid && !eop_seen && !sym_err, "R1",
            "events in reset", int'(sop_valid), 0);
      rst_n = 1'b1;
      wait_cycles(2);
      check(sop_type == 3'd0 && data_nibble == 4'h0, "R1", "reset values",
            int'(sop_type), 0);

      // R2: enabled but no idle yet, a full start sequence is ignored.
      enable = 1'b1;
      send_set(S1, S1, S1, S2);
      send_sym(DCODE[3]);
      drained("R2");

      // R4 R7 R8: exact type 0, all sixteen nibbles, then the end code.
      start_packet();
      expect_ev(EV_SOP, 0, "R4");
      send_set(S1, S1, S1, S2);
      for (int n = 0; n < 16; n++) begin
         expect_ev(EV_DATA, n, "R7");
         send_sym(DCODE[n]);
      end
      expect_ev(EV_EOP, 0, "R8");
      send_sym(EOPC);
      drained("R8");

      // R5: type 1 with its first symbol corrupted.
      start_packet();
      expect_ev(EV_SOP, 1, "R5");
      send_set(BAD, S1, S3, S3);
      expect_ev(EV_DATA, 10, "R7");
      send_sym(DCODE[10]);
      expect_ev(EV_DATA, 5, "R7");
      send_sym(DCODE[5]);
      expect_ev(EV_EOP, 0, "R8");
      send_sym(EOPC);
      drained("R5");

      // R9: type 2, then an invalid code; later bits need a fresh idle.
      start_packet();
      expect_ev(EV_SOP, 2, "R4");
      send_set(S1, S3, S1, S3);
      expect_ev(EV_ERR, 0, "R9");
      send_sym(BAD);
      send_set(S1, S1, S1, S2);
      send_sym(DCODE[1]);
      drained("R9");

      // R10: hard reset has no data phase.
      start_packet();
      expect_ev(EV_SOP, 3, "R10");
      send_set(R1, R1, R1, RR2);
      send_sym(DCODE[2]);
      send_sym(EOPC);
      drained("R10");

      // R5 R10: cable reset with one symbol corrupted.
      start_packet();
      expect_ev(EV_SOP, 4, "R5");
      send_set(R1, S1, BAD, S3);
      send_sym(DCODE[7]);
      drained("R10");

      // R6: S1,S1,S1,S3 meets both type 0 and type 1; type 0 wins.
      start_packet();
      expect_ev(EV_SOP, 0, "R6");
      send_set(S1, S1, S1, S3);
      expect_ev(EV_EOP, 0, "R8");
      send_sym(EOPC);
      drained("R6");

      // R5: only two matching symbols is not accepted.
      start_packet();
      send_set(S1, S1, BAD, BAD);
      drained("R5");
      @(negedge clk); enable = 1'b0;
      @(negedge clk); enable = 1'b1;

      // R1: disabling mid-packet stops the data phase.
      start_packet();
      expect_ev(EV_SOP, 0, "R1");
      send_set(S1, S1, S1, S2);
      expect_ev(EV_DATA, 9, "R1");
      send_sym(DCODE[9]);
      @(negedge clk); enable = 1'b0;
      send_sym(DCODE[4]);
      @(negedge clk); enable = 1'b1;
      send_sym(DCODE[6]);
      send_sym(EOPC);
      drained("R1");

      // R3: fewer than 20 bits after idle cannot complete a sequence.
      @(negedge clk); line_idle = 1'b1;
      wait_cycles(2);
      line_idle = 1'b0;
      send_sym(S1); send_sym(S1); send_sym(S2);
      drained("R3");
      expect_ev(EV_SOP, 0, "R3");
      send_sym(S2);
      drained("R3");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule